// File: doc/BRIEF.md
# Inter-Processor Mailbox Register Bank

This block holds sixteen 32-bit mailboxes for a cluster of four cores, four mailboxes for each core. A core passes a message to another core by writing bits into one of the target's mailboxes. The target consumes the message by clearing those bits. Each mailbox appears at two word addresses. A write to the first address ORs the data into the mailbox. A write to the second address clears every bit that is 1 in the data. A read of the second address returns the mailbox contents, so a sender can poll it until it reads zero.

Every mailbox drives one interrupt line. The line is high while the mailbox holds any set bit and the target core has enabled that mailbox in its own enable register. The line drops only after the last bit has been cleared or the enable bit has been removed. The block sits on a simple register bus with an address, write data, write and read strobes, and a combinational read-data return.

Top module: `mbox_bank`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), every mailbox reads zero, every enable register reads zero, and all interrupt lines are low.
- R2: Mailbox m (0..3) of core c (0..3) sits at byte address 0x80 + 16*c + 4*m for setting and at 0xC0 + 16*c + 4*m for clearing. A write to one mailbox leaves every other mailbox unchanged.
- R3: A write to a set address ORs `wrData` into that mailbox at the next rising clock edge.
- R4: A write to a clear address clears, at the next rising edge, exactly the bits that are 1 in `wrData`.
- R5: A read at a clear address returns the current mailbox contents. A read at a set address returns zero.
- R6: Core c has an enable register at 0x50 + 4*c. A write stores `wrData[3:0]`, and bit m enables mailbox m of that core. A read returns the stored bits in `rdData[3:0]` with all upper bits zero.
- R7: Interrupt line `irq[4*c+m]` is high when mailbox m of core c is nonzero and its enable bit is set. It is registered and changes at the same rising edge that captures the write that changes either condition.
- R8: Addresses outside the three windows, and addresses whose two low bits are not zero, read as zero and ignore writes.
- R9: While `rdEn` is low, `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Byte address of the access |
| wrData | input | 32 | Write data |
| wrEn | input | 1 | Write strobe, sampled at the rising edge |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Combinational read data |
| irq | output | 16 | Per-mailbox level interrupts, index 4*core+mailbox |

## Verification
The bench sets bits in two writes and then clears them in two partial writes. A design that replaced the contents instead of ORing them, or that cleared the whole word, would return the wrong residue. It places messages in mailboxes of different cores and reads back neighbouring mailboxes, which exposes a core/mailbox index swap or a wrong stride. It also checks the interrupt at the half cycle before and after the capturing edge, so an extra pipeline stage would show up as a late line. A misaligned write and an unmapped write are chosen so that any false decode changes a visible bit. A reset in the middle of the run and a read with `rdEn` low show any state that fails to reset or any read data that leaks through.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  parameter int NUM_CORES      = 4;
  parameter int BOXES_PER_CORE = 4;
  parameter int DATA_W         = 32;

  localparam int CORE_W    = $clog2(NUM_CORES);
  localparam int BOX_W     = $clog2(BOXES_PER_CORE);
  localparam int NUM_BOXES = NUM_CORES * BOXES_PER_CORE;

  // strobes the decoder hands to the storage datapath
  typedef struct packed {
    logic              setWe;
    logic              clrWe;
    logic              maskWe;
    logic              rdBox;
    logic              rdMask;
    logic [CORE_W-1:0] core;
    logic [BOX_W-1:0]  box;
  } mboxCtrl_t;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] SET_BASE  = 'h80,
  parameter logic [ADDR_W-1:0] CLR_BASE  = 'hC0,
  parameter logic [ADDR_W-1:0] MASK_BASE = 'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output mboxCtrl_t         ctrl
);
  localparam logic [ADDR_W-1:0] BOX_SPAN  = ADDR_W'(NUM_BOXES * 4);
  localparam logic [ADDR_W-1:0] MASK_SPAN = ADDR_W'(NUM_CORES * 4);

  logic [ADDR_W-1:0] setOff, clrOff, maskOff;
  logic aligned, inSet, inClr, inMask;

  always_comb begin
    setOff  = addr - SET_BASE;
    clrOff  = addr - CLR_BASE;
    maskOff = addr - MASK_BASE;
    aligned = (addr[1:0] == 2'b00);
    inSet   = aligned && (addr >= SET_BASE)  && (setOff  < BOX_SPAN);
    inClr   = aligned && (addr >= CLR_BASE)  && (clrOff  < BOX_SPAN);
    inMask  = aligned && (addr >= MASK_BASE) && (maskOff < MASK_SPAN);

    ctrl        = '0;
    ctrl.setWe  = wrEn && inSet;
    ctrl.clrWe  = wrEn && inClr;
    ctrl.maskWe = wrEn && inMask;
    ctrl.rdBox  = rdEn && inClr;
    ctrl.rdMask = rdEn && inMask;
    if (inSet) begin
      ctrl.core = setOff[2+BOX_W +: CORE_W];
      ctrl.box  = setOff[2 +: BOX_W];
    end else if (inClr) begin
      ctrl.core = clrOff[2+BOX_W +: CORE_W];
      ctrl.box  = clrOff[2 +: BOX_W];
    end else if (inMask) begin
      ctrl.core = maskOff[2 +: CORE_W];
    end
  end

  // R2: at most one write window is hit per access
  p_one_window_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.setWe, ctrl.clrWe, ctrl.maskWe}));

  // R8: a misaligned address raises no strobe
  p_misaligned_r8: assert property (@(posedge clk) disable iff (rst)
    (addr[1:0] != 2'b00) |-> !(ctrl.setWe || ctrl.clrWe || ctrl.maskWe || ctrl.rdBox || ctrl.rdMask));
endmodule

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  mboxCtrl_t            ctrl,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_BOXES-1:0] irq
);
  logic [DATA_W-1:0]         boxQ     [NUM_BOXES];
  logic [DATA_W-1:0]         boxNext  [NUM_BOXES];
  logic [BOXES_PER_CORE-1:0] maskQ    [NUM_CORES];
  logic [BOXES_PER_CORE-1:0] maskNext [NUM_CORES];
  logic [NUM_BOXES-1:0]      irqQ, irqNext, setHit, clrHit;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign maskNext[c] = (ctrl.maskWe && ctrl.core == CORE_W'(c))
                         ? wrData[BOXES_PER_CORE-1:0] : maskQ[c];
  end

  for (genvar i = 0; i < NUM_BOXES; i++) begin : g_box
    localparam int C = i / BOXES_PER_CORE;
    localparam int B = i % BOXES_PER_CORE;
    logic hit;
    assign hit       = (ctrl.core == CORE_W'(C)) && (ctrl.box == BOX_W'(B));
    assign setHit[i] = ctrl.setWe && hit;
    assign clrHit[i] = ctrl.clrWe && hit;
    assign boxNext[i] = clrHit[i] ? (boxQ[i] & ~wrData)
                      : setHit[i] ? (boxQ[i] | wrData) : boxQ[i];
    assign irqNext[i] = (|boxNext[i]) && maskNext[C][B];

    // R3: every written bit is present after a set write
    p_set_or_r3: assert property (@(posedge clk) disable iff (rst)
      setHit[i] |=> ((boxQ[i] & $past(wrData)) == $past(wrData)));
    // R4: every written bit is gone after a clear write
    p_clr_bits_r4: assert property (@(posedge clk) disable iff (rst)
      clrHit[i] |=> ((boxQ[i] & $past(wrData)) == '0));
    // R8: a mailbox not addressed keeps its value
    p_box_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !(setHit[i] || clrHit[i]) |=> $stable(boxQ[i]));
    // R7: a line is high only for an enabled, nonempty mailbox
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
      irqQ[i] |-> (maskQ[C][B] && (boxQ[i] != '0)));
    p_irq_raise_r7: assert property (@(posedge clk) disable iff (rst)
      (maskQ[C][B] && (boxQ[i] != '0)) |-> irqQ[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BOXES; i++) boxQ[i] <= '0;
      for (int c = 0; c < NUM_CORES; c++) maskQ[c] <= '0;
      irqQ <= '0;
    end else begin
      for (int i = 0; i < NUM_BOXES; i++) boxQ[i] <= boxNext[i];
      for (int c = 0; c < NUM_CORES; c++) maskQ[c] <= maskNext[c];
      irqQ <= irqNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (ctrl.rdBox)
      rdData = boxQ[{ctrl.core, ctrl.box}];
    else if (ctrl.rdMask)
      rdData[BOXES_PER_CORE-1:0] = maskQ[ctrl.core];
  end

  assign irq = irqQ;
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 wrEn,
  input  logic                 rdEn,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_BOXES-1:0] irq
);
  mboxCtrl_t ctrl;

  mbox_decode #(.ADDR_W(ADDR_W)) i_decode (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .ctrl(ctrl)
  );

  mbox_store i_store (
    .clk(clk), .rst(rst), .ctrl(ctrl), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // R9: no read strobe, no read data
  p_idle_read_r9: assert property (@(posedge clk) disable iff (rst)
    !rdEn |-> (rdData == '0));
endmodule

// File: tb/test_mbox_bank.sv
module test_mbox_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_WR = 2'd1, OP_RD = 2'd2, OP_IRQ = 2'd3;
  localparam int NVEC = 31;
  // {op, addr, data/expected, requirement}
  localparam logic [45:0] VEC [NVEC] = '{
    {OP_RD,  8'hCC, 32'h0000_0000, 4'd1},  // R1 empty after reset
    {OP_WR,  8'h8C, 32'h0000_00F0, 4'd3},  // R3 core0 mailbox3
    {OP_RD,  8'hCC, 32'h0000_00F0, 4'd3},
    {OP_WR,  8'h8C, 32'h0000_000F, 4'd3},
    {OP_RD,  8'hCC, 32'h0000_00FF, 4'd3},  // R3 OR, not replace
    {OP_IRQ, 8'h00, 32'h0000_0000, 4'd7},  // R7 masked
    {OP_WR,  8'h50, 32'h0000_0008, 4'd6},  // R6 enable core0 mailbox3
    {OP_IRQ, 8'h00, 32'h0000_0008, 4'd7},
    {OP_RD,  8'h50, 32'h0000_0008, 4'd6},
    {OP_WR,  8'hCC, 32'h0000_000F, 4'd4},  // R4 partial clear
    {OP_RD,  8'hCC, 32'h0000_00F0, 4'd4},
    {OP_IRQ, 8'h00, 32'h0000_0008, 4'd7},  // R7 still high
    {OP_WR,  8'hCC, 32'h0000_00F0, 4'd4},
    {OP_RD,  8'hCC, 32'h0000_0000, 4'd4},
    {OP_IRQ, 8'h00, 32'h0000_0000, 4'd7},  // R7 drops
    {OP_WR,  8'hA4, 32'hDEAD_BEEF, 4'd2},  // R2 core2 mailbox1
    {OP_RD,  8'hE4, 32'hDEAD_BEEF, 4'd5},  // R5
    {OP_RD,  8'hA4, 32'h0000_0000, 4'd5},  // R5 set window reads zero
    {OP_WR,  8'h58, 32'hFFFF_FFF2, 4'd6},
    {OP_RD,  8'h58, 32'h0000_0002, 4'd6},  // R6 upper bits dropped
    {OP_IRQ, 8'h00, 32'h0000_0200, 4'd7},
    {OP_WR,  8'h40, 32'hFFFF_FFFF, 4'd8},  // R8 unmapped
    {OP_RD,  8'h40, 32'h0000_0000, 4'd8},
    {OP_WR,  8'hA5, 32'h0000_0010, 4'd8},  // R8 misaligned
    {OP_RD,  8'hE4, 32'hDEAD_BEEF, 4'd8},
    {OP_WR,  8'hBC, 32'h0000_0001, 4'd2},  // R2 core3 mailbox3
    {OP_RD,  8'hFC, 32'h0000_0001, 4'd2},
    {OP_RD,  8'hCC, 32'h0000_0000, 4'd2},
    {OP_IRQ, 8'h00, 32'h0000_0200, 4'd7},
    {OP_WR,  8'h5C, 32'h0000_000F, 4'd6},
    {OP_IRQ, 8'h00, 32'h0000_8200, 4'd7}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic [15:0] irq;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  mbox_bank i_mbox_bank (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr   = a;
    wrData = d;
    wrEn   = (op == OP_WR);
    rdEn   = (op == OP_RD);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check({16'h0, irq}, 32'h0, "R1 irq after reset");

    for (int k = 0; k < NVEC; k++) begin
      logic [1:0]  op;
      logic [7:0]  a;
      logic [31:0] d;
      logic [3:0]  rq;
      {op, a, d, rq} = VEC[k];
      drive(op, a, d);
      if (op == OP_RD)
        check(rdData, d, $sformatf("R%0d vector %0d read", rq, k));
      else if (op == OP_IRQ)
        check({16'h0, irq}, d, $sformatf("R%0d vector %0d irq", rq, k));
    end

    // R9: read strobe low gives zero even at a live mailbox
    drive(2'd0, 8'hE4, 32'h0);
    check(rdData, 32'h0, "R9 idle read");
    drive(OP_RD, 8'hE4, 32'h0);
    check(rdData, 32'hDEAD_BEEF, "R9 strobe restores data");

    // R7: line changes at the capturing edge, not before
    drive(OP_WR, 8'h8C, 32'h0000_0001);
    check({16'h0, irq}, 32'h0000_8200, "R7 before edge");
    @(posedge clk); #1;
    wrEn = 1'b0;
    check({16'h0, irq}, 32'h0000_8208, "R7 after edge");

    // R7: removing the enable drops the line
    drive(OP_WR, 8'h50, 32'h0);
    drive(2'd0, 8'h00, 32'h0);
    check({16'h0, irq}, 32'h0000_8200, "R7 mask removed");

    // R1: reset in mid-run clears everything
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check({16'h0, irq}, 32'h0, "R1 irq cleared");
    drive(OP_RD, 8'hE4, 32'h0);
    check(rdData, 32'h0, "R1 mailbox cleared");
    drive(OP_RD, 8'h58, 32'h0);
    check(rdData, 32'h0, "R1 enable cleared");
    drive(OP_RD, 8'hFC, 32'h0);
    check(rdData, 32'h0, "R1 core3 mailbox cleared");
    rdEn = 1'b0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule